// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to a state where it can accept normal traffic. After a start strobe it holds the command bus at NOP for a programmable settling pause. It then steps through a fixed command order. First come a precharge of all banks and a load of the extended mode register that switches the memory's DLL on. Next come a mode register load that resets the DLL and a programmable DLL lock wait. A second precharge of all banks follows, then a counted run of auto-refresh commands, and last a mode register load with the DLL reset bit cleared. After that final load it raises a done flag. From then on it keeps the bus at NOP until the next reset.

Every wait between two commands is counted in clock cycles from a programmable value: precharge period, mode-load period, refresh cycle time, lock time and the initial pause. A wait programmed as zero still costs one NOP cycle. The mode and extended-mode words come from inputs. The sequencer forces only the DLL-related bits. The state machine has fifteen named states:
- IDLE
- PAUSE
- PRE1 with its wait W_PRE1
- EMRS with W_EMRS
- MRS_RST with the lock wait W_LOCK
- PRE2 with W_PRE2
- REF with W_REF
- MRS_FIN with W_FIN
- DONE

Its transitions are:
- IDLE to PAUSE when start is seen.
- Out of every wait state once its counter reaches its last cycle.
- Out of every command state after a single cycle.
- W_REF back to REF until the refresh count is met, then on to MRS_FIN.
- W_FIN to DONE, where it stays.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held and after it is released, cmd is NOP (4'b0111, bit 3 is chip select active low, then RAS_n, CAS_n, WE_n), bank and addr are zero and done is low; no command appears until start is sampled high in IDLE.
- R2: Start sampled high in IDLE at clock edge s gives max(pause_cycles,1) NOP cycles, then PRECHARGE (4'b0010) in the cycle after edge s+max(pause_cycles,1), with addr bit 10 high, all other addr bits zero and bank zero.
- R3: The extended mode load (cmd 4'b0000, bank 2'b01, addr = emode_val with bit 0 cleared so the DLL is enabled) follows the first precharge by max(trp_cycles,1)+1 cycles.
- R4: The DLL-reset mode load (cmd 4'b0000, bank 2'b00, addr = mode_val with bit 8 set) follows the extended mode load by max(tmrd_cycles,1)+1 cycles.
- R5: The second precharge (same encoding as R2) follows the DLL-reset mode load by max(lock_cycles,1)+1 cycles, with only NOP in between.
- R6: Auto-refresh commands (4'b0001, bank and addr zero) are issued one at a time, max(refresh_count,1) of them. The first comes max(trp_cycles,1)+1 cycles after the second precharge, and each later one comes max(trfc_cycles,1)+1 cycles after the one before.
- R7: The final mode load (cmd 4'b0000, bank 2'b00, addr = mode_val with bit 8 cleared) follows the last refresh by max(trfc_cycles,1)+1 cycles and never precedes the full refresh count.
- R8: done rises max(tmrd_cycles,1)+1 cycles after the final mode load and stays high with cmd at NOP until reset.
- R9: A start strobe sampled in any state other than IDLE, including DONE, has no effect on cmd, bank, addr or done.
- R10: Reset asserted mid-sequence returns the outputs to the R1 state at once, and the next start replays the whole sequence from the pause.
- R11: Two commands are never issued back to back, and on every NOP cycle bank and addr are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (honoured only in IDLE) |
| pause_cycles | input | PW (16) | Power-up pause length in cycles |
| lock_cycles | input | PW (16) | DLL lock wait in cycles |
| trp_cycles | input | GW (6) | Gap after each precharge |
| tmrd_cycles | input | GW (6) | Gap after each mode or extended-mode load |
| trfc_cycles | input | GW (6) | Gap after each auto-refresh |
| refresh_count | input | RW (4) | Number of auto-refreshes (0 treated as 1) |
| mode_val | input | AW (13) | Mode register word |
| emode_val | input | AW (13) | Extended mode register word |
| cmd | output | 4 | {CS_n, RAS_n, CAS_n, WE_n} |
| bank | output | BW (2) | Bank address |
| addr | output | AW (13) | Address bus |
| done | output | 1 | Initialization complete |

## Verification
The assertions check a set of rules on every cycle:
- NOP cycles keep the address buses at zero.
- No two commands are adjacent.
- A precharge always targets all banks.
- The extended mode load never disables the DLL.
- The refresh tally never exceeds the programmed count, and it is complete before the final mode load.
- done, once raised, stays high with the bus quiet.

Other properties need the bench's scenarios with their cycle-exact scoreboard:
- The exact command order and the spacing of every gap, including the zero-gap and zero-count minimums.
- Start strobes that must be ignored.
- A reset in the middle of a run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LMR = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_PRE1,
        ST_W_PRE1,
        ST_EMRS,
        ST_W_EMRS,
        ST_MRS_RST,
        ST_W_LOCK,
        ST_PRE2,
        ST_W_PRE2,
        ST_REF,
        ST_W_REF,
        ST_MRS_FIN,
        ST_W_FIN,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/ddr_init_timer.sv
// Down-counter shared by every wait state. Loaded in the cycle before the
// wait; the wait ends on the cycle where the count is at or below one, so a
// load value of N yields max(N,1) wait cycles.
module ddr_init_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q <= CW'(1));

endmodule

// File: rtl/ddr_init_refctr.sv
// Counts issued auto-refresh commands against the programmed target.
// A target of zero is promoted to one.
module ddr_init_refctr #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    input  logic [RW-1:0] target,
    output logic          reached
);

    logic [RW-1:0] issued_q;
    logic [RW-1:0] goal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= '0;
        end else if (clear) begin
            issued_q <= '0;
        end else if (bump) begin
            issued_q <= issued_q + 1'b1;
        end
    end

    always_comb begin
        goal = target;
        if (target == '0) begin
            goal = RW'(1);
        end
    end

    assign reached = (issued_q >= goal);

endmodule

// File: rtl/ddr_init_cmdgen.sv
// Output decode: command, bank and address as a function of the state.
module ddr_init_cmdgen
    import ddr_init_pkg::*;
#(
    parameter int AW          = 13,
    parameter int BW          = 2,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8,
    parameter int DLL_DIS_BIT = 0
) (
    input  seq_state_e     state,
    input  logic [AW-1:0]  mode_val,
    input  logic [AW-1:0]  emode_val,
    output logic [3:0]     cmd,
    output logic [BW-1:0]  bank,
    output logic [AW-1:0]  addr,
    output logic           done
);

    localparam logic [BW-1:0] BANK_MR  = BW'(0);
    localparam logic [BW-1:0] BANK_EMR = BW'(1);

    always_comb begin
        cmd  = CMD_NOP;
        bank = '0;
        addr = '0;
        done = 1'b0;
        unique case (state)
            ST_PRE1, ST_PRE2: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_EMRS: begin
                cmd               = CMD_LMR;
                bank              = BANK_EMR;
                addr              = emode_val;
                addr[DLL_DIS_BIT] = 1'b0;
            end
            ST_MRS_RST: begin
                cmd               = CMD_LMR;
                bank              = BANK_MR;
                addr              = mode_val;
                addr[DLL_RST_BIT] = 1'b1;
            end
            ST_REF: begin
                cmd = CMD_REF;
            end
            ST_MRS_FIN: begin
                cmd               = CMD_LMR;
                bank              = BANK_MR;
                addr              = mode_val;
                addr[DLL_RST_BIT] = 1'b0;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            ST_IDLE, ST_PAUSE, ST_W_PRE1, ST_W_EMRS, ST_W_LOCK,
            ST_W_PRE2, ST_W_REF, ST_W_FIN: begin
                cmd = CMD_NOP;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int AW          = 13,
    parameter int BW          = 2,
    parameter int PW          = 16,
    parameter int GW          = 6,
    parameter int RW          = 4,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8,
    parameter int DLL_DIS_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] pause_cycles,
    input  logic [PW-1:0] lock_cycles,
    input  logic [GW-1:0] trp_cycles,
    input  logic [GW-1:0] tmrd_cycles,
    input  logic [GW-1:0] trfc_cycles,
    input  logic [RW-1:0] refresh_count,
    input  logic [AW-1:0] mode_val,
    input  logic [AW-1:0] emode_val,
    output logic [3:0]    cmd,
    output logic [BW-1:0] bank,
    output logic [AW-1:0] addr,
    output logic          done
);

    localparam int PAD = PW - GW;

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic          tmr_load;
    logic [PW-1:0] tmr_val;
    logic          tmr_last;
    logic          ref_clear;
    logic          ref_bump;
    logic          ref_reached;

    logic [PW-1:0] trp_ext;
    logic [PW-1:0] tmrd_ext;
    logic [PW-1:0] trfc_ext;

    assign trp_ext  = {{PAD{1'b0}}, trp_cycles};
    assign tmrd_ext = {{PAD{1'b0}}, tmrd_cycles};
    assign trfc_ext = {{PAD{1'b0}}, trfc_cycles};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_d = ST_PAUSE;
            ST_PAUSE:   if (tmr_last) state_d = ST_PRE1;
            ST_PRE1:                  state_d = ST_W_PRE1;
            ST_W_PRE1:  if (tmr_last) state_d = ST_EMRS;
            ST_EMRS:                  state_d = ST_W_EMRS;
            ST_W_EMRS:  if (tmr_last) state_d = ST_MRS_RST;
            ST_MRS_RST:               state_d = ST_W_LOCK;
            ST_W_LOCK:  if (tmr_last) state_d = ST_PRE2;
            ST_PRE2:                  state_d = ST_W_PRE2;
            ST_W_PRE2:  if (tmr_last) state_d = ST_REF;
            ST_REF:                   state_d = ST_W_REF;
            ST_W_REF: begin
                if (tmr_last) begin
                    state_d = ref_reached ? ST_MRS_FIN : ST_REF;
                end
            end
            ST_MRS_FIN:               state_d = ST_W_FIN;
            ST_W_FIN:   if (tmr_last) state_d = ST_DONE;
            ST_DONE:                  state_d = ST_DONE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer load selection: the cycle before each wait state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load = start;
                tmr_val  = pause_cycles;
            end
            ST_PRE1, ST_PRE2: begin
                tmr_load = 1'b1;
                tmr_val  = trp_ext;
            end
            ST_EMRS, ST_MRS_FIN: begin
                tmr_load = 1'b1;
                tmr_val  = tmrd_ext;
            end
            ST_MRS_RST: begin
                tmr_load = 1'b1;
                tmr_val  = lock_cycles;
            end
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = trfc_ext;
            end
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    assign ref_clear = (state_q == ST_PRE2);
    assign ref_bump  = (state_q == ST_REF);

    ddr_init_timer #(
        .CW (PW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    ddr_init_refctr #(
        .RW (RW)
    ) u_refctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_clear),
        .bump    (ref_bump),
        .target  (refresh_count),
        .reached (ref_reached)
    );

    ddr_init_cmdgen #(
        .AW          (AW),
        .BW          (BW),
        .AP_BIT      (AP_BIT),
        .DLL_RST_BIT (DLL_RST_BIT),
        .DLL_DIS_BIT (DLL_DIS_BIT)
    ) u_cmdgen (
        .state     (state_q),
        .mode_val  (mode_val),
        .emode_val (emode_val),
        .cmd       (cmd),
        .bank      (bank),
        .addr      (addr),
        .done      (done)
    );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
    import ddr_init_pkg::*;
#(
    parameter int AW          = 13,
    parameter int BW          = 2,
    parameter int RW          = 4,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8,
    parameter int DLL_DIS_BIT = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] refresh_count,
    input logic [3:0]    cmd,
    input logic [BW-1:0] bank,
    input logic [AW-1:0] addr,
    input logic          done
);

    logic [RW:0] refs_seen;
    logic [RW:0] refs_goal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refs_seen <= '0;
        end else if (cmd == CMD_PRE) begin
            refs_seen <= '0;
        end else if (cmd == CMD_REF) begin
            refs_seen <= refs_seen + 1'b1;
        end
    end

    assign refs_goal = (refresh_count == '0) ? (RW+1)'(1) : {1'b0, refresh_count};

    a_r11_nop_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |-> (bank == '0 && addr == '0));

    a_r11_no_adjacent_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    a_r2_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (addr[AP_BIT] && bank == '0));

    a_r3_emrs_dll_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR && bank == BW'(1)) |-> !addr[DLL_DIS_BIT]);

    a_r6_ref_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (refs_seen < refs_goal));

    a_r7_refs_before_final: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR && bank == '0 && !addr[DLL_RST_BIT]) |-> (refs_seen == refs_goal));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_NOP));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .AW          (AW),
    .BW          (BW),
    .RW          (RW),
    .AP_BIT      (AP_BIT),
    .DLL_RST_BIT (DLL_RST_BIT),
    .DLL_DIS_BIT (DLL_DIS_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_count (refresh_count),
    .cmd           (cmd),
    .bank          (bank),
    .addr          (addr),
    .done          (done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pause_cycles = '0;
    logic [15:0] lock_cycles = '0;
    logic [5:0]  trp_cycles = '0;
    logic [5:0]  tmrd_cycles = '0;
    logic [5:0]  trfc_cycles = '0;
    logic [3:0]  refresh_count = '0;
    logic [12:0] mode_val = '0;
    logic [12:0] emode_val = '0;
    logic [3:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] addr;
    logic        done;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] addr;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    mon_en = 1'b0;
    string unexp_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    ddr_init_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .pause_cycles  (pause_cycles),
        .lock_cycles   (lock_cycles),
        .trp_cycles    (trp_cycles),
        .tmrd_cycles   (tmrd_cycles),
        .trfc_cycles   (trfc_cycles),
        .refresh_count (refresh_count),
        .mode_val      (mode_val),
        .emode_val     (emode_val),
        .cmd           (cmd),
        .bank          (bank),
        .addr          (addr),
        .done          (done)
    );

    // Monitor: pops expected commands as the design issues them
    always @(negedge clk) begin
        if (mon_en && cmd !== NOP) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL %s: unexpected cmd=%b bank=%0d addr=%h at cycle %0d, expected NOP",
                         unexp_tag, cmd, bank, addr, cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cmd !== e.cmd || bank !== e.bank || addr !== e.addr || cyc != e.cyc) begin
                    fails++;
                    $display("FAIL %s: got cmd=%b bank=%0d addr=%h cyc=%0d, expected cmd=%b bank=%0d addr=%h cyc=%0d",
                             e.tag, cmd, bank, addr, cyc, e.cmd, e.bank, e.addr, e.cyc);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic push(input logic [3:0] c, input logic [1:0] b,
                        input logic [12:0] a, input int t, input string tag);
        exp_t e;
        e.cmd = c; e.bank = b; e.addr = a; e.cyc = t; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        exp_q.delete();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
    endtask

    // Driver: programs inputs, pulses start and queues the expected commands.
    // Returns the cycle where done must first be seen.
    task automatic launch(input int p, input int lk, input int trp, input int tmrd,
                          input int trfc, input int nref, input logic [12:0] mv,
                          input logic [12:0] ev, output int t_done);
        int t;
        logic [12:0] pre_a;
        logic [12:0] mrs_rst;
        logic [12:0] mrs_fin;
        logic [12:0] emr;
        pause_cycles  = 16'(p);
        lock_cycles   = 16'(lk);
        trp_cycles    = 6'(trp);
        tmrd_cycles   = 6'(tmrd);
        trfc_cycles   = 6'(trfc);
        refresh_count = 4'(nref);
        mode_val      = mv;
        emode_val     = ev;
        pre_a   = 13'h0400;                 // bit 10
        mrs_rst = mv | 13'h0100;            // bit 8 set
        mrs_fin = mv & ~13'h0100;           // bit 8 cleared
        emr     = ev & ~13'h0001;           // bit 0 cleared
        @(negedge clk);
        start = 1'b1;
        t = cyc + 1 + atleast1(p);
        push(PRE, 2'd0, pre_a, t, "R2");
        t += 1 + atleast1(trp);
        push(LMR, 2'd1, emr, t, "R3");
        t += 1 + atleast1(tmrd);
        push(LMR, 2'd0, mrs_rst, t, "R4");
        t += 1 + atleast1(lk);
        push(PRE, 2'd0, pre_a, t, "R5");
        t += 1 + atleast1(trp);
        for (int i = 0; i < atleast1(nref); i++) begin
            push(REF, 2'd0, 13'h0000, t, "R6");
            t += 1 + atleast1(trfc);
        end
        push(LMR, 2'd0, mrs_fin, t, "R7");
        t += 1 + atleast1(tmrd);
        t_done = t;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input int t_done);
        while (cyc < t_done - 1) @(negedge clk);
        check(done === 1'b0, "R8", "done one cycle early", int'(done), 0);
        @(negedge clk);
        check(done === 1'b1, "R8", "done at its cycle", int'(done), 1);
        check(exp_q.size() == 0, "R6", "commands still pending", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int td;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(cmd === NOP, "R1", "cmd in reset", int'(cmd), int'(NOP));
        check(done === 1'b0, "R1", "done in reset", int'(done), 0);
        check(bank === 2'd0 && addr === 13'd0, "R1", "bank/addr in reset", int'(addr), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        unexp_tag = "R1";
        repeat (20) @(negedge clk);
        check(cmd === NOP && done === 1'b0, "R1", "idle without start", int'(cmd), int'(NOP));

        // Run A with a stray start mid-sequence (R9)
        unexp_tag = "R9";
        launch(25, 12, 3, 2, 6, 2, 13'h0032, 13'h0001, td);
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run(td);

        // R9: start in DONE is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        check(done === 1'b1, "R9", "done after stray start", int'(done), 1);
        check(cmd === NOP, "R8", "bus quiet in done", int'(cmd), int'(NOP));

        // R10: reset mid-run, then idle, then full replay
        do_reset();
        unexp_tag = "R10";
        launch(5, 30, 2, 2, 4, 2, 13'h0022, 13'h0000, td);
        repeat (20) @(negedge clk);
        mon_en = 1'b0;
        exp_q.delete();
        rst_n = 1'b0;
        @(negedge clk);
        check(cmd === NOP && done === 1'b0, "R10", "outputs under mid-run reset", int'(cmd), int'(NOP));
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (30) @(negedge clk);
        check(done === 1'b0, "R10", "done after reset", int'(done), 0);

        // Run C: all gaps zero, refresh count zero (treated as one)
        unexp_tag = "R11";
        launch(0, 0, 0, 0, 0, 0, 13'h1163, 13'h0006, td);
        finish_run(td);

        // Run D: unit gaps, three refreshes
        do_reset();
        launch(1, 1, 1, 1, 1, 3, 13'h0062, 13'h0003, td);
        finish_run(td);

        // Run E: longer refresh burst after a replay
        do_reset();
        launch(40, 20, 4, 3, 9, 5, 13'h0121, 13'h0000, td);
        finish_run(td);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule